// File: doc/BRIEF.md
# Transaction Status and Failure Recorder

This block follows the transactional state of a single hardware thread. The pipeline sends it one-cycle event pulses: open a transaction, close one, abort explicitly, suspend, resume, and report a failure event. Each pulse comes with an instruction address, and failure events also carry a cause selector, an 8-bit failure code, an exactness flag and the current privilege state. From these pulses the block keeps the nesting level, the thread's active and suspended flags, and the failure-handler address of the outermost transaction.

When a failure is recorded, the block stores a 64-bit exception-summary word and the address of the failing instruction. It sends a one-cycle fetch redirect to the outermost handler and sets the condition field that the instruction after a begin branches on. Read ports return the summary word, its upper half, the handler address and the failing-instruction address. Bit positions in the summary word are numbered with bit 0 as the most significant bit, so position p is `rd_summary[63-p]`.

Top module: `tm_status_rec`

## Requirements
- R1: Synchronous reset sets `tx_active`, `tx_suspended`, `redirect_vld`, `cond_field`, `rd_summary`, `rd_handler` and `rd_fail_addr` to zero.
- R2: A begin while not transactional sets the level field (positions 52..63, `rd_summary[11:0]`) to 1. It loads `rd_handler` with the begin address plus `INSN_BYTES`, sets `cond_field` to 4'b0000 and copies `ev_rot` into position 38. A begin while transactional and below `MAX_LEVEL` adds one to the level, sets `cond_field` to 4'b0100 and leaves the handler and position 38 unchanged.
- R3: An end at level 1 clears the level to 0 and leaves the transactional state. An end at a higher level subtracts one. An end while not transactional has no effect.
- R4: A begin at level `MAX_LEVEL` records a nesting-overflow failure: cause position 9, failure code 8'h01 (persistent, position 7), exact bit set. The level field stays at `MAX_LEVEL`.
- R5: A failure event while transactional records the failure. The failure code goes to positions 0..7. Exactly one cause position is set: selector values 0..8 map to positions 8..16, and larger values map to position 15. The privilege state goes to positions 34..35 and `ev_exact` to position 37. Position 36 is set, and `rd_fail_addr` takes the event address.
- R6: An abort while transactional records a failure with cause position 31, the given failure code, the exact bit set and `rd_fail_addr` equal to the abort address.
- R7: The cycle after any recorded failure, `redirect_vld` pulses for one cycle with `redirect_addr` equal to the outermost handler. `cond_field` becomes 4'b1010, so its bit 2 (`cond_field[1]`) is set. The thread leaves the transactional state, and the level field holds the failure level.
- R8: A suspend while transactional sets `tx_suspended`, and a resume clears it. While suspended, begin and end have no effect. A failure recorded while suspended sets position 32.
- R9: A failure or abort event while not transactional has no effect.
- R10: Positions 17..30, 33 and 39..51 always read zero. `rd_summary_hi` returns positions 0..31.
- R11: When several pulses arrive in one cycle, only the highest-ranked accepted one acts. The ranking is failure, abort, begin, end, suspend, resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_begin | input | 1 | Begin pulse |
| ev_rot | input | 1 | Begin opens a rollback-only transaction |
| ev_end | input | 1 | End pulse |
| ev_abort | input | 1 | Explicit abort pulse |
| ev_suspend | input | 1 | Suspend pulse |
| ev_resume | input | 1 | Resume pulse |
| ev_fail | input | 1 | Failure event pulse |
| ev_cause | input | 4 | Failure cause selector |
| ev_fcode | input | 8 | Failure code |
| ev_exact | input | 1 | Event address is exact |
| ev_priv | input | 2 | Privilege state at the event |
| ev_pc | input | ADDR_W | Instruction address of the event |
| tx_active | output | 1 | Thread is transactional |
| tx_suspended | output | 1 | Transaction is suspended |
| cond_field | output | 4 | Condition field for the instruction after a begin |
| redirect_vld | output | 1 | Fetch redirect pulse |
| redirect_addr | output | ADDR_W | Redirect target |
| rd_summary | output | 64 | Exception-summary word |
| rd_summary_hi | output | 32 | Positions 0..31 of the summary |
| rd_handler | output | ADDR_W | Failure-handler address |
| rd_fail_addr | output | ADDR_W | Failing-instruction address |

## Verification
Every result is registered once, so the state flags, level field, handler, condition field, summary word, failing address and redirect pulse all change exactly one clock edge after the cycle that carries the event. The redirect pulse is gone one edge later. The bench drives each event on a falling edge, lets its behavioural model advance on the next rising edge, and compares every output at the falling edge after that. The directed checks read the ports at the same point, one cycle after the stimulus. For the redirect, a second read one cycle later confirms the pulse has dropped.

// File: rtl/tm_rec_pkg.sv
package tm_rec_pkg;

    localparam int LEVEL_W = 12;
    localparam int CODE_W  = 8;
    localparam int PRIV_W  = 2;
    localparam int SEL_W   = 4;
    localparam int POS_W   = 5;

    localparam logic [POS_W-1:0] POS_FIRST_CAUSE = 5'd8;
    localparam logic [POS_W-1:0] POS_NEST_OVF    = 5'd9;
    localparam logic [POS_W-1:0] POS_IMPL        = 5'd15;
    localparam logic [POS_W-1:0] POS_ABORT       = 5'd31;
    localparam logic [CODE_W-1:0] CODE_NEST_OVF  = 8'h01;

    localparam logic [3:0] COND_OUTER  = 4'b0000;
    localparam logic [3:0] COND_NESTED = 4'b0100;
    localparam logic [3:0] COND_FAILED = 4'b1010;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_OPEN,
        ACT_NEST,
        ACT_POP,
        ACT_CLOSE,
        ACT_SUSP,
        ACT_RESUME,
        ACT_FAIL
    } act_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [POS_W-1:0]  cause_pos;
        logic              exact;
    } fail_info_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [POS_W-1:0]  cause_pos;
        logic              in_susp;
        logic [PRIV_W-1:0] priv;
        logic              summary;
        logic              exact;
        logic              rollback_only;
    } fail_rec_t;

    function automatic logic [POS_W-1:0] cause_pos_of(input logic [SEL_W-1:0] sel);
        if (sel <= 4'd8)
            return POS_FIRST_CAUSE + POS_W'(sel);
        return POS_IMPL;
    endfunction

    // Position p (0 = most significant) lands at word bit 63-p.
    function automatic logic [63:0] pack_summary(input fail_rec_t r,
                                                 input logic [LEVEL_W-1:0] lvl);
        logic [63:0] w;
        w = '0;
        w[63:56] = r.code;
        if (r.summary)
            w[6'd63 - 6'(r.cause_pos)] = 1'b1;
        w[31]    = r.in_susp;
        w[29:28] = r.priv;
        w[27]    = r.summary;
        w[26]    = r.exact;
        w[25]    = r.rollback_only;
        w[11:0]  = lvl;
        return w;
    endfunction

endpackage

// File: rtl/tm_event_decode.sv
module tm_event_decode
    import tm_rec_pkg::*;
#(
    parameter int MAX_LEVEL = 6
) (
    input  logic               ev_begin,
    input  logic               ev_end,
    input  logic               ev_abort,
    input  logic               ev_suspend,
    input  logic               ev_resume,
    input  logic               ev_fail,
    input  logic [SEL_W-1:0]   ev_cause,
    input  logic [CODE_W-1:0]  ev_fcode,
    input  logic               ev_exact,
    input  logic               in_tx,
    input  logic               in_susp,
    input  logic [LEVEL_W-1:0] level,
    output act_e               act,
    output fail_info_t         finfo
);
    localparam logic [LEVEL_W-1:0] LVL_MAX = LEVEL_W'(MAX_LEVEL);
    localparam logic [LEVEL_W-1:0] LVL_ONE = LEVEL_W'(1);

    always_comb begin
        act             = ACT_IDLE;
        finfo.code      = ev_fcode;
        finfo.cause_pos = cause_pos_of(ev_cause);
        finfo.exact     = ev_exact;
        if (ev_fail && in_tx) begin
            act = ACT_FAIL;
        end else if (ev_abort && in_tx) begin
            act             = ACT_FAIL;
            finfo.cause_pos = POS_ABORT;
            finfo.exact     = 1'b1;
        end else if (ev_begin && !in_susp) begin
            if (!in_tx) begin
                act = ACT_OPEN;
            end else if (level >= LVL_MAX) begin
                act             = ACT_FAIL;
                finfo.code      = CODE_NEST_OVF;
                finfo.cause_pos = POS_NEST_OVF;
                finfo.exact     = 1'b1;
            end else begin
                act = ACT_NEST;
            end
        end else if (ev_end && in_tx && !in_susp) begin
            act = (level == LVL_ONE) ? ACT_CLOSE : ACT_POP;
        end else if (ev_suspend && in_tx && !in_susp) begin
            act = ACT_SUSP;
        end else if (ev_resume && in_susp) begin
            act = ACT_RESUME;
        end
    end

endmodule

// File: rtl/tm_level_ctr.sv
module tm_level_ctr
    import tm_rec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  act_e               act,
    output logic               in_tx,
    output logic               in_susp,
    output logic [LEVEL_W-1:0] level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_tx   <= 1'b0;
            in_susp <= 1'b0;
            level   <= '0;
        end else begin
            unique case (act)
                ACT_OPEN: begin
                    in_tx <= 1'b1;
                    level <= LEVEL_W'(1);
                end
                ACT_NEST:   level <= level + LEVEL_W'(1);
                ACT_POP:    level <= level - LEVEL_W'(1);
                ACT_CLOSE: begin
                    in_tx <= 1'b0;
                    level <= '0;
                end
                ACT_SUSP:   in_susp <= 1'b1;
                ACT_RESUME: in_susp <= 1'b0;
                ACT_FAIL: begin
                    in_tx   <= 1'b0;
                    in_susp <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tm_fail_capture.sv
module tm_fail_capture
    import tm_rec_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  fail_info_t        finfo,
    input  logic [ADDR_W-1:0] ev_pc,
    input  logic              ev_rot,
    input  logic [PRIV_W-1:0] ev_priv,
    input  logic              in_susp,
    output fail_rec_t         rec,
    output logic [ADDR_W-1:0] handler,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [3:0]        cond,
    output logic              redirect_vld,
    output logic [ADDR_W-1:0] redirect_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec           <= '0;
            handler       <= '0;
            fail_addr     <= '0;
            cond          <= COND_OUTER;
            redirect_vld  <= 1'b0;
            redirect_addr <= '0;
        end else begin
            redirect_vld <= 1'b0;
            unique case (act)
                ACT_OPEN: begin
                    handler           <= ev_pc + ADDR_W'(INSN_BYTES);
                    rec.rollback_only <= ev_rot;
                    cond              <= COND_OUTER;
                end
                ACT_NEST: cond <= COND_NESTED;
                ACT_FAIL: begin
                    rec.code      <= finfo.code;
                    rec.cause_pos <= finfo.cause_pos;
                    rec.exact     <= finfo.exact;
                    rec.in_susp   <= in_susp;
                    rec.priv      <= ev_priv;
                    rec.summary   <= 1'b1;
                    fail_addr     <= ev_pc;
                    cond          <= COND_FAILED;
                    redirect_vld  <= 1'b1;
                    redirect_addr <= handler;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tm_status_rec.sv
module tm_status_rec
    import tm_rec_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int MAX_LEVEL  = 6,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_begin,
    input  logic              ev_rot,
    input  logic              ev_end,
    input  logic              ev_abort,
    input  logic              ev_suspend,
    input  logic              ev_resume,
    input  logic              ev_fail,
    input  logic [3:0]        ev_cause,
    input  logic [7:0]        ev_fcode,
    input  logic              ev_exact,
    input  logic [1:0]        ev_priv,
    input  logic [ADDR_W-1:0] ev_pc,
    output logic              tx_active,
    output logic              tx_suspended,
    output logic [3:0]        cond_field,
    output logic              redirect_vld,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [63:0]       rd_summary,
    output logic [31:0]       rd_summary_hi,
    output logic [ADDR_W-1:0] rd_handler,
    output logic [ADDR_W-1:0] rd_fail_addr
);
    act_e               act;
    fail_info_t         finfo;
    fail_rec_t          rec;
    logic               in_tx;
    logic               in_susp;
    logic [LEVEL_W-1:0] level;

    tm_event_decode #(.MAX_LEVEL(MAX_LEVEL)) u_dec (
        .ev_begin   (ev_begin),
        .ev_end     (ev_end),
        .ev_abort   (ev_abort),
        .ev_suspend (ev_suspend),
        .ev_resume  (ev_resume),
        .ev_fail    (ev_fail),
        .ev_cause   (ev_cause),
        .ev_fcode   (ev_fcode),
        .ev_exact   (ev_exact),
        .in_tx      (in_tx),
        .in_susp    (in_susp),
        .level      (level),
        .act        (act),
        .finfo      (finfo)
    );

    tm_level_ctr u_lvl (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .in_tx   (in_tx),
        .in_susp (in_susp),
        .level   (level)
    );

    tm_fail_capture #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_cap (
        .clk           (clk),
        .rst           (rst),
        .act           (act),
        .finfo         (finfo),
        .ev_pc         (ev_pc),
        .ev_rot        (ev_rot),
        .ev_priv       (ev_priv),
        .in_susp       (in_susp),
        .rec           (rec),
        .handler       (rd_handler),
        .fail_addr     (rd_fail_addr),
        .cond          (cond_field),
        .redirect_vld  (redirect_vld),
        .redirect_addr (redirect_addr)
    );

    assign tx_active     = in_tx;
    assign tx_suspended  = in_susp;
    assign rd_summary    = pack_summary(rec, level);
    assign rd_summary_hi = rd_summary[63:32];

endmodule

// File: rtl/tm_status_chk.sv
module tm_status_chk #(
    parameter int ADDR_W    = 64,
    parameter int MAX_LEVEL = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_active,
    input logic              tx_suspended,
    input logic [3:0]        cond_field,
    input logic              redirect_vld,
    input logic [63:0]       rd_summary,
    input logic [ADDR_W-1:0] rd_handler
);
    function automatic logic [63:0] reserved_mask();
        logic [63:0] m;
        m = '0;
        for (int p = 17; p <= 30; p++) m[63-p] = 1'b1;
        m[63-33] = 1'b1;
        for (int p = 39; p <= 51; p++) m[63-p] = 1'b1;
        return m;
    endfunction

    localparam logic [63:0] RSV = reserved_mask();

    a_r7_redirect_one_cycle: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |=> !redirect_vld);

    a_r7_redirect_leaves_tx: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |-> (!tx_active && cond_field == 4'b1010));

    a_r8_susp_within_tx: assert property (@(posedge clk) disable iff (rst)
        tx_suspended |-> tx_active);

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_summary & RSV) == 64'd0);

    a_r5_onehot_cause: assert property (@(posedge clk) disable iff (rst)
        rd_summary[27] |-> $countones(rd_summary[55:32]) == 1);

    a_r2_level_range: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> (rd_summary[11:0] >= 12'd1 && rd_summary[11:0] <= 12'(MAX_LEVEL)));

    a_r2_handler_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_active && $past(tx_active)) |-> $stable(rd_handler));

    a_r3_idle_level_zero: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !rd_summary[27]) |-> rd_summary[11:0] == 12'd0);

endmodule

bind tm_status_rec tm_status_chk #(.ADDR_W(ADDR_W), .MAX_LEVEL(MAX_LEVEL)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_active    (tx_active),
    .tx_suspended (tx_suspended),
    .cond_field   (cond_field),
    .redirect_vld (redirect_vld),
    .rd_summary   (rd_summary),
    .rd_handler   (rd_handler)
);

// File: tb/sim_tm_status_rec.sv
module sim_tm_status_rec;
    localparam int MAXL = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_begin = 0, b_rot = 0, b_end = 0, b_abort = 0;
    logic        b_susp = 0, b_resume = 0, b_fail = 0, b_exact = 0;
    logic [3:0]  b_cause = 0;
    logic [7:0]  b_fcode = 0;
    logic [1:0]  b_priv = 0;
    logic [63:0] b_pc = 0;

    logic        tx_active, tx_suspended, redirect_vld;
    logic [3:0]  cond_field;
    logic [63:0] redirect_addr, rd_summary, rd_handler, rd_fail_addr;
    logic [31:0] rd_summary_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    tm_status_rec #(.ADDR_W(64), .MAX_LEVEL(MAXL), .INSN_BYTES(4)) u0 (
        .clk(clk), .rst(rst),
        .ev_begin(b_begin), .ev_rot(b_rot), .ev_end(b_end), .ev_abort(b_abort),
        .ev_suspend(b_susp), .ev_resume(b_resume), .ev_fail(b_fail),
        .ev_cause(b_cause), .ev_fcode(b_fcode), .ev_exact(b_exact),
        .ev_priv(b_priv), .ev_pc(b_pc),
        .tx_active(tx_active), .tx_suspended(tx_suspended),
        .cond_field(cond_field), .redirect_vld(redirect_vld),
        .redirect_addr(redirect_addr), .rd_summary(rd_summary),
        .rd_summary_hi(rd_summary_hi), .rd_handler(rd_handler),
        .rd_fail_addr(rd_fail_addr)
    );

    // Behavioural reference state
    bit          m_in, m_susp, m_redir, m_fs, m_exact, m_rot, m_spnd;
    int          m_level, m_cause;
    logic [7:0]  m_code;
    logic [1:0]  m_priv;
    logic [3:0]  m_cond;
    logic [63:0] m_handler, m_faddr, m_raddr;

    function automatic logic [63:0] exp_word();
        logic [63:0] w = '0;
        for (int i = 0; i < 8; i++) w[63-i] = m_code[7-i];
        if (m_fs) w[63-m_cause] = 1'b1;
        w[63-32] = m_spnd;
        w[63-34] = m_priv[1];
        w[63-35] = m_priv[0];
        w[63-36] = m_fs;
        w[63-37] = m_exact;
        w[63-38] = m_rot;
        for (int i = 0; i < 12; i++) w[i] = m_level[i];
        return w;
    endfunction

    task automatic m_record(input int pos, input logic [7:0] code, input bit ex);
        m_code  = code;
        m_cause = pos;
        m_exact = ex;
        m_spnd  = m_susp;
        m_priv  = b_priv;
        m_fs    = 1;
        m_faddr = b_pc;
        m_cond  = 4'b1010;
        m_redir = 1;
        m_raddr = m_handler;
        m_in    = 0;
        m_susp  = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_in = 0; m_susp = 0; m_redir = 0; m_fs = 0; m_exact = 0; m_rot = 0;
            m_spnd = 0; m_level = 0; m_cause = 0; m_code = 0; m_priv = 0;
            m_cond = 0; m_handler = 0; m_faddr = 0; m_raddr = 0;
        end else begin
            m_redir = 0;
            if (b_fail && m_in)
                m_record((b_cause <= 8) ? 8 + int'(b_cause) : 15, b_fcode, b_exact);
            else if (b_abort && m_in)
                m_record(31, b_fcode, 1);
            else if (b_begin && !m_susp) begin
                if (!m_in) begin
                    m_in = 1; m_level = 1; m_handler = b_pc + 64'd4;
                    m_rot = b_rot; m_cond = 4'b0000;
                end else if (m_level == MAXL) begin
                    m_record(9, 8'h01, 1);
                end else begin
                    m_level++; m_cond = 4'b0100;
                end
            end else if (b_end && m_in && !m_susp) begin
                m_level--;
                if (m_level == 0) m_in = 0;
            end else if (b_susp && m_in && !m_susp)
                m_susp = 1;
            else if (b_resume && m_susp)
                m_susp = 0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 tx_active", 64'(tx_active), 64'(m_in));
        chk("R8 tx_suspended", 64'(tx_suspended), 64'(m_susp));
        chk("R7 cond_field", 64'(cond_field), 64'(m_cond));
        chk("R7 redirect_vld", 64'(redirect_vld), 64'(m_redir));
        if (m_redir) chk("R7 redirect_addr", redirect_addr, m_raddr);
        chk("R5 summary", rd_summary, exp_word());
        chk("R10 summary_hi", 64'(rd_summary_hi), 64'(exp_word() >> 32));
        chk("R2 handler", rd_handler, m_handler);
        chk("R5 fail_addr", rd_fail_addr, m_faddr);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        b_begin = 0; b_end = 0; b_abort = 0; b_susp = 0; b_resume = 0; b_fail = 0;
        b_rot = 0;
    endtask

    task automatic do_begin(input logic [63:0] pc, input bit rot);
        b_begin = 1; b_pc = pc; b_rot = rot; tick();
    endtask

    task automatic do_end();
        b_end = 1; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 reset active", 64'(tx_active), 0);
        chk("R1 reset summary", rd_summary, 0);
        chk("R1 reset handler", rd_handler, 0);
        chk("R1 reset cond", 64'(cond_field), 0);

        // R2 outer and nested begin
        do_begin(64'h1000, 0);
        chk("R2 outer handler", rd_handler, 64'h1004);
        chk("R2 outer level", 64'(rd_summary[11:0]), 1);
        do_begin(64'h1100, 1);
        do_begin(64'h1200, 0);
        chk("R2 nested level", 64'(rd_summary[11:0]), 3);
        chk("R2 nested cond", 64'(cond_field), 64'b0100);
        chk("R2 nested handler kept", rd_handler, 64'h1004);
        chk("R2 rot unchanged on nest", 64'(rd_summary[25]), 0);

        // R3 end handling
        do_end(); do_end();
        chk("R3 pop level", 64'(rd_summary[11:0]), 1);
        do_end();
        chk("R3 close level", 64'(rd_summary[11:0]), 0);
        chk("R3 close inactive", 64'(tx_active), 0);
        do_end();
        chk("R3 end ignored idle", 64'(rd_summary[11:0]), 0);

        // R8 suspended failure, R5 cause map
        do_begin(64'h2000, 1);
        chk("R2 rot set", 64'(rd_summary[25]), 1);
        b_susp = 1; tick();
        chk("R8 suspended", 64'(tx_suspended), 1);
        do_begin(64'h2100, 0);
        do_end();
        chk("R8 begin/end ignored while suspended", 64'(rd_summary[11:0]), 1);
        b_fail = 1; b_cause = 4'd3; b_fcode = 8'h81; b_priv = 2'b10; b_exact = 0;
        b_pc = 64'h2abc; tick();
        chk("R5 cause pos 11", 64'(rd_summary[63-11]), 1);
        chk("R8 suspended flag", 64'(rd_summary[31]), 1);
        chk("R5 failing address", rd_fail_addr, 64'h2abc);
        chk("R7 redirect pulse", 64'(redirect_vld), 1);
        chk("R7 redirect target", redirect_addr, 64'h2004);
        chk("R7 cond bit2", 64'(cond_field[1]), 1);
        tick();
        chk("R7 redirect drops", 64'(redirect_vld), 0);

        // R9 events ignored when idle
        b_abort = 1; b_pc = 64'h9999; tick();
        b_fail = 1; tick();
        chk("R9 idle abort ignored", rd_fail_addr, 64'h2abc);
        chk("R9 idle no redirect", 64'(redirect_vld), 0);

        // R4 nesting overflow
        do_begin(64'h3000, 0);
        for (int i = 1; i < MAXL; i++) do_begin(64'h3000 + 64'(i * 16), 0);
        chk("R4 at max", 64'(rd_summary[11:0]), MAXL);
        do_begin(64'h3f00, 0);
        chk("R4 cause pos 9", 64'(rd_summary[63-9]), 1);
        chk("R4 code", 64'(rd_summary[63:56]), 8'h01);
        chk("R4 level kept", 64'(rd_summary[11:0]), MAXL);
        chk("R4 redirect", redirect_addr, 64'h3004);

        // R6 abort
        do_begin(64'h4000, 0);
        do_begin(64'h4010, 0);
        b_abort = 1; b_fcode = 8'h55; b_pc = 64'h4444; b_exact = 0; tick();
        chk("R6 abort cause", 64'(rd_summary[32]), 1);
        chk("R6 abort exact", 64'(rd_summary[26]), 1);
        chk("R6 abort code", 64'(rd_summary_hi[31:24]), 8'h55);
        chk("R6 level at failure", 64'(rd_summary[11:0]), 2);
        chk("R8 not suspended flag", 64'(rd_summary[31]), 0);

        // R11 priority, R5 out-of-range selector
        do_begin(64'h5000, 0);
        b_fail = 1; b_end = 1; b_begin = 1; b_cause = 4'd12; b_fcode = 8'h10;
        b_exact = 1; b_priv = 2'b01; b_pc = 64'h5050; tick();
        chk("R11 fail wins", 64'(redirect_vld), 1);
        chk("R5 sel>8 -> pos 15", 64'(rd_summary[63-15]), 1);
        chk("R5 priv", 64'(rd_summary[29:28]), 2'b01);
        chk("R10 reserved", rd_summary & 64'h0000_7ffe_4000_1000 | (rd_summary & 64'h0000_0000_01ff_f000), 0);

        // R8 suspend/resume round trip
        do_begin(64'h6000, 0);
        b_susp = 1; tick();
        b_resume = 1; tick();
        chk("R8 resumed", 64'(tx_suspended), 0);
        do_end();
        chk("R3 end after resume", 64'(tx_active), 0);

        repeat (2) tick();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule